// File: doc/BRIEF.md
# ADC Sample FIFO with Sticky Error Flags

This block buffers converted analog samples between a data converter and a processor. It holds four 12-bit entries. A sample enters the queue when the converter raises its data-valid strobe. It also enters when the processor writes a dummy value, which lets software be exercised without real conversions. When both sources are active in the same cycle, the converter sample is taken and the processor value is dropped.

The processor pops the oldest entry with a read strobe. The popped value appears on a registered read-data output one clock later. A five-bit status word reports the fill state and two error flags. Overflow and underflow are sticky, and while one of them is set the matching pointer stops moving. A single flush pulse empties the queue and clears every flag.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the status word is 5'b00001 (only the empty flag set) and the read data is zero.
- R2: A converter strobe or a processor write pushes one sample. If both occur in the same cycle, only the converter sample is stored.
- R3: A read on a non-empty FIFO with underflow clear removes the oldest sample. That sample appears on the read data after the next rising edge. Samples come out in the order they were pushed.
- R4: Status bit 0 (empty) is 1 exactly when no sample is stored. Status bit 2 (full) is 1 exactly when four samples are stored.
- R5: Status bit 1 (almost full) is 1 only when exactly three samples are stored, and it is 0 when the FIFO is full.
- R6: A push attempted while full sets status bit 4 (overflow). Overflow stays set until a flush. While it is set, no push is accepted, even after reads make room.
- R7: A read attempted while empty sets status bit 3 (underflow) and leaves the read data at the last sample read. Underflow stays set until a flush. While it is set, reads do not remove samples and the read data does not change.
- R8: A flush empties the FIFO, clears both error flags and sets the read data to zero. It takes precedence over any read or push in the same cycle.
- R9: A read and a push in the same cycle with one to three samples stored both take effect, and the sample count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_valid | input | 1 | Converter sample strobe |
| cnv_data | input | 12 | Converter sample |
| cpu_wr | input | 1 | Processor dummy-sample write strobe |
| cpu_wdata | input | 12 | Processor dummy sample |
| cpu_rd | input | 1 | Processor read strobe (pops oldest) |
| flush | input | 1 | Synchronous flush pulse |
| rd_data | output | 12 | Last sample read |
| status | output | 5 | {overflow, underflow, full, almost full, empty} |

## Verification
Two pairs of events can fall in the same cycle: a converter strobe together with a processor write, and a read together with a push. The bench drives both pairs on the same clock at fill levels of zero, one to three, and four. It then judges the stored order, the occupancy and the flags against a queue-based model. Flush is also driven together with reads and writes, to show that it takes precedence.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  typedef struct packed {
    logic ovf;
    logic udf;
    logic full;
    logic afull;
    logic empty;
  } fifo_stat_t;
endpackage

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic                         pop_req,
  input  logic                         flush,
  output logic                         push_ok,
  output logic                         pop_ok,
  output logic [$clog2(DEPTH)-1:0]     wptr,
  output logic [$clog2(DEPTH)-1:0]     rptr,
  output fifo_stat_t                   stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] wptr_d, rptr_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          is_full, is_empty;

  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign push_ok  = push_req & ~ovf_q & ~is_full & ~flush;
  assign pop_ok   = pop_req & ~udf_q & ~is_empty & ~flush;

  always_comb begin
    cnt_d  = cnt_q;
    wptr_d = wptr;
    rptr_d = rptr;
    ovf_d  = ovf_q | (push_req & is_full);
    udf_d  = udf_q | (pop_req & is_empty);
    if (push_ok) begin
      wptr_d = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    end
    if (pop_ok) begin
      rptr_d = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (flush) begin
      cnt_d  = '0;
      wptr_d = '0;
      rptr_d = '0;
      ovf_d  = 1'b0;
      udf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      wptr  <= wptr_d;
      rptr  <= rptr_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  always_comb begin
    stat.ovf   = ovf_q;
    stat.udf   = udf_q;
    stat.full  = is_full;
    stat.afull = (cnt_q == CW'(DEPTH - 1));
    stat.empty = is_empty;
  end
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_ok,
  input  logic                     pop_ok,
  input  logic                     flush,
  input  logic [$clog2(DEPTH)-1:0] wptr,
  input  logic [$clog2(DEPTH)-1:0] rptr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic entry_en;
    assign entry_en = push_ok & (wptr == AW'(gi));
    always_ff @(posedge clk) begin
      if (entry_en) begin
        mem[gi] <= wdata;
      end
    end
  end

  assign rdata_en = pop_ok | flush;
  assign rdata_d  = flush ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rdata_en) begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_valid,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        status
);
  localparam int AW = $clog2(DEPTH);

  logic              push_req, push_ok, pop_ok;
  logic [DATA_W-1:0] push_data;
  logic [AW-1:0]     wptr, rptr;
  fifo_stat_t        stat;

  assign push_req  = cnv_valid | cpu_wr;
  assign push_data = cnv_valid ? cnv_data : cpu_wdata;

  adc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (cpu_rd),
    .flush    (flush),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wptr     (wptr),
    .rptr     (rptr),
    .stat     (stat)
  );

  adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .flush   (flush),
    .wptr    (wptr),
    .rptr    (rptr),
    .wdata   (push_data),
    .rdata   (rd_data)
  );

  assign status = stat;
endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_valid,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              flush,
  input logic [DATA_W-1:0] rd_data,
  input logic [4:0]        status
);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !flush) |=> status[4]);

  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !flush) |=> status[3]);

  a_r6_no_push_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !cpu_rd && !flush) |=> $stable(status[2:0]));

  a_r7_rdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !flush) |=> $stable(rd_data));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (status == 5'b00001 && rd_data == '0));

  a_r5_afull_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[2:0]) <= 1);

  a_r6_ovf_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(status[2]) && $past(cnv_valid || cpu_wr));
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_valid (cnv_valid),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .flush     (flush),
  .rd_data   (rd_data),
  .status    (status)
);

// File: tb/adc_sample_fifo_test.sv
`timescale 1ns/1ps
module adc_sample_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_valid = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0, flush = 1'b0;
  logic [11:0] cnv_data = '0, cpu_wdata = '0;
  logic [11:0] rd_data;
  logic [4:0]  status;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [11:0] q[$];
  logic        m_ovf = 1'b0, m_udf = 1'b0;
  logic [11:0] m_last = '0;

  always #5 clk = ~clk;

  adc_sample_fifo uut (
    .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .cnv_data(cnv_data),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .flush(flush),
    .rd_data(rd_data), .status(status)
  );

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int pre = q.size();
    if (flush) begin
      q.delete(); m_ovf = 0; m_udf = 0; m_last = '0;
    end else begin
      if (cpu_rd) begin
        if (!m_udf && pre > 0) m_last = q.pop_front();
        else if (pre == 0) m_udf = 1;
      end
      if (cnv_valid || cpu_wr) begin
        if (pre == 4) m_ovf = 1;
        else if (!m_ovf) q.push_back(cnv_valid ? cnv_data : cpu_wdata);
      end
    end
  endtask

  task automatic compare();
    chk("R4 empty", {11'd0, status[0]}, {11'd0, q.size() == 0});
    chk("R5 almost_full", {11'd0, status[1]}, {11'd0, q.size() == 3});
    chk("R4 full", {11'd0, status[2]}, {11'd0, q.size() == 4});
    chk("R7 underflow", {11'd0, status[3]}, {11'd0, m_udf});
    chk("R6 overflow", {11'd0, status[4]}, {11'd0, m_ovf});
    chk("R3 rd_data", rd_data, m_last);
  endtask

  task automatic cyc(input logic cv, input logic [11:0] cd, input logic cw,
                     input logic [11:0] cwd, input logic rd, input logic fl);
    cnv_valid = cv; cnv_data = cd; cpu_wr = cw; cpu_wdata = cwd;
    cpu_rd = rd; flush = fl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    cnv_valid = 0; cpu_wr = 0; cpu_rd = 0; flush = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", {7'd0, status}, 12'h001);
    chk("R1 reset rd_data", rd_data, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: converter and processor pushes, converter wins on collision
    cyc(1, 12'h111, 0, 0, 0, 0);
    cyc(0, 0, 1, 12'h222, 0, 0);
    cyc(1, 12'h333, 1, 12'hBAD, 0, 0);
    chk("R5 afull at three", {11'd0, status[1]}, 12'd1);
    cyc(0, 0, 1, 12'h444, 0, 0);
    chk("R4 full at four", {7'd0, status}, 12'h004);
    // R6: overflow while full, then frozen after reads
    cyc(1, 12'h555, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R3 oldest first", rd_data, 12'h111);
    cyc(0, 0, 1, 12'h666, 0, 0);
    chk("R6 push dropped after overflow", {7'd0, status}, 12'h012);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R2 converter priority", rd_data, 12'h222);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R2 converter sample stored", rd_data, 12'h333);
    // R8: flush with simultaneous read and write
    cyc(1, 12'h777, 0, 0, 1, 1);
    chk("R8 flush clears", {rd_data[6:0], status}, 12'h001);
    // R7: underflow returns previous sample, read pointer frozen
    cyc(1, 12'h0A1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R7 underflow keeps last", rd_data, 12'h0A1);
    cyc(0, 0, 1, 12'h0B2, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R7 read frozen", rd_data, 12'h0A1);
    cyc(0, 0, 0, 0, 0, 1);
    // R9: simultaneous read and push at levels 1..3, and at 0 and 4
    cyc(1, 12'h101, 0, 0, 0, 0);
    cyc(1, 12'h102, 0, 0, 1, 0);
    chk("R9 count held at one", {7'd0, status}, 12'h000);
    cyc(0, 0, 1, 12'h103, 0, 0);
    cyc(0, 0, 1, 12'h104, 1, 0);
    cyc(1, 12'h105, 0, 0, 0, 0);
    cyc(1, 12'h106, 0, 0, 1, 0);
    chk("R9 count held at three", {7'd0, status}, 12'h002);
    cyc(1, 12'h107, 0, 0, 0, 0);
    cyc(1, 12'h108, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 12'h109, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++)
      cyc(i[0], 12'(i * 37), i[1], 12'(i * 11), i[2] ^ i[0], i == 30);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule